// File: doc/BRIEF.md
# Multiprocessor Interrupt Distribution Arbiter

This block takes interrupt requests from sixteen lines and hands each one to exactly one of four CPUs. Each line carries a routing entry that holds a mode bit and a 2-bit target CPU.

- **Fixed routing:** a line in fixed mode always goes to the CPU named in its entry.
- **Load-balancing routing:** a line in load-balancing mode goes to the CPU that reports the lowest current task priority. Ties are broken by per-CPU fairness counters.

One request is accepted per cycle. When several lines request together, the lowest-numbered line is taken first. The other lines keep their valid high and wait until they are accepted. In the following cycle the block emits a one-cycle delivery: a one-hot CPU select together with the line number.

The fairness counters give a rotating share among equally idle CPUs. After each load-balancing delivery, the receiving CPU's counter restarts from zero. The counters of every other CPU count up and stop at their maximum. Among CPUs that share the lowest priority, the one whose counter is largest wins. If those counters are also equal, the lowest CPU index wins.

Top module: `irq_dist_top`

## Requirements
- R1: In every cycle `req_ready_o` is one-hot on the lowest-numbered line whose `req_valid_i` bit is high, and zero when no line is valid. A line is accepted in a cycle where both its valid and ready bits are high. Lines that are not accepted stay pending for as long as their valid is held.
- R2: An acceptance at a clock edge makes `dlv_valid_o` high for exactly the next cycle. In that cycle `dlv_cpu_o` has exactly one bit set (bit k selects CPU k) and `dlv_line_o` holds the binary index of the accepted line. With no acceptance, `dlv_valid_o` is low in the next cycle.
- R3: For a line whose mode bit is 0 (fixed), the delivery selects the CPU held in that line's entry.
- R4: A table write (`tbl_we_i` high at a clock edge) stores `tbl_cpu_i` as the target and `tbl_dyn_i` as the mode bit (1 = load-balancing) for line `tbl_line_i`. Requests accepted at later edges use the new entry.
- R5: For a line in load-balancing mode, the delivery selects a CPU whose 4-bit priority on `cpu_prio_i` is the lowest of the four at the accepting edge. CPU k uses bits [4k+3:4k].
- R6: When several CPUs share the lowest priority, the one with the largest fairness counter is selected.
- R7: When priorities and counters are both tied, the lowest CPU index is selected.
- R8: On each load-balancing delivery, the selected CPU's 8-bit counter becomes 0. Every other counter increments by one, saturating at 255.
- R9: Fixed-mode deliveries, and cycles with no acceptance, leave all counters unchanged.
- R10: Reset sets every table entry to fixed mode with target CPU 0, clears all counters, and holds `dlv_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 16 | Per-line request valid |
| req_ready_o | output | 16 | Per-line accept, one-hot or zero |
| cpu_prio_i | input | 16 | Four 4-bit current task priorities, CPU k in bits [4k+3:4k] |
| tbl_we_i | input | 1 | Routing table write enable |
| tbl_line_i | input | 4 | Line whose entry is written |
| tbl_cpu_i | input | 2 | Fixed target CPU to store |
| tbl_dyn_i | input | 1 | Mode bit to store, 1 = load-balancing |
| dlv_valid_o | output | 1 | Delivery valid, one cycle per accepted request |
| dlv_cpu_o | output | 4 | One-hot selected CPU |
| dlv_line_o | output | 4 | Line number of the delivered request |

## Verification
The assertions check the following on every cycle:
- the ready vector's lowest-line one-hot shape;
- that every acceptance yields exactly one one-hot delivery naming a line that was ready;
- that a load-balancing winner had no CPU with a lower priority;
- that the winner's counter is cleared and no counter wraps;
- that fixed deliveries leave the counters still.

Only the bench scenarios can show the following:
- the exact tie-break order between counters and CPU index;
- saturation after long runs of wins by one CPU;
- table write effects and reset defaults;
- the ordering of drained simultaneous requests.

The bench infers these from later choices, because the counters are not visible at the ports.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  parameter int unsigned NUM_CPU_DEF   = 4;
  parameter int unsigned NUM_LINES_DEF = 16;
  parameter int unsigned PRIO_W_DEF    = 4;
  parameter int unsigned CNT_W_DEF     = 8;

  typedef enum logic {
    MODE_FIXED = 1'b0,
    MODE_BAL   = 1'b1
  } route_mode_e;
endpackage

// File: rtl/irq_dist_pick.sv
module irq_dist_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  valid_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o   = '0;
    any_o   = 1'b0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
    if (any_o) grant_o[idx_o] = 1'b1;
  end
endmodule

// File: rtl/irq_dist_table.sv
module irq_dist_table
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned NUM_CPU   = 4,
  localparam int unsigned LW = $clog2(NUM_LINES),
  localparam int unsigned CW = $clog2(NUM_CPU)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [LW-1:0] wline_i,
  input  logic [CW-1:0] wcpu_i,
  input  logic          wdyn_i,
  input  logic [LW-1:0] rline_i,
  output logic [CW-1:0] rcpu_o,
  output route_mode_e   rmode_o
);
  logic [CW-1:0] cpu_q  [NUM_LINES];
  route_mode_e   mode_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NUM_LINES); i++) begin
        cpu_q[i]  <= '0;
        mode_q[i] <= MODE_FIXED;
      end
    end else if (we_i) begin
      cpu_q[wline_i]  <= wcpu_i;
      mode_q[wline_i] <= wdyn_i ? MODE_BAL : MODE_FIXED;
    end
  end

  assign rcpu_o  = cpu_q[rline_i];
  assign rmode_o = mode_q[rline_i];
endmodule

// File: rtl/irq_dist_bal_sel.sv
module irq_dist_bal_sel #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned CW = $clog2(NUM_CPU)
) (
  input  logic [NUM_CPU*PRIO_W-1:0] prio_i,
  input  logic [NUM_CPU*CNT_W-1:0]  cnt_i,
  output logic [CW-1:0]             win_o
);
  logic [PRIO_W-1:0] best_prio;
  logic [CNT_W-1:0]  best_cnt;

  // linear scan: strict compares keep the lowest index on full ties
  always_comb begin
    win_o     = '0;
    best_prio = prio_i[PRIO_W-1:0];
    best_cnt  = cnt_i[CNT_W-1:0];
    for (int c = 1; c < int'(NUM_CPU); c++) begin
      if ((prio_i[c*PRIO_W +: PRIO_W] < best_prio) ||
          ((prio_i[c*PRIO_W +: PRIO_W] == best_prio) &&
           (cnt_i[c*CNT_W +: CNT_W] > best_cnt))) begin
        win_o     = CW'(c);
        best_prio = prio_i[c*PRIO_W +: PRIO_W];
        best_cnt  = cnt_i[c*CNT_W +: CNT_W];
      end
    end
  end
endmodule

// File: rtl/irq_dist_fair_cnt.sv
module irq_dist_fair_cnt #(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned CNT_W   = 8,
  localparam int unsigned CW = $clog2(NUM_CPU)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_i,
  input  logic [CW-1:0]            win_i,
  output logic [NUM_CPU*CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < int'(NUM_CPU); g++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else if (upd_i) begin
        if (win_i == CW'(g))   cnt_q <= '0;
        else if (cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
      end
    end
    assign cnt_o[g*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/irq_dist_top.sv
module irq_dist_top
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU   = NUM_CPU_DEF,
  parameter int unsigned NUM_LINES = NUM_LINES_DEF,
  parameter int unsigned PRIO_W    = PRIO_W_DEF,
  parameter int unsigned CNT_W     = CNT_W_DEF,
  localparam int unsigned LW = $clog2(NUM_LINES),
  localparam int unsigned CW = $clog2(NUM_CPU)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_LINES-1:0]      req_valid_i,
  output logic [NUM_LINES-1:0]      req_ready_o,
  input  logic [NUM_CPU*PRIO_W-1:0] cpu_prio_i,
  input  logic                      tbl_we_i,
  input  logic [LW-1:0]             tbl_line_i,
  input  logic [CW-1:0]             tbl_cpu_i,
  input  logic                      tbl_dyn_i,
  output logic                      dlv_valid_o,
  output logic [NUM_CPU-1:0]        dlv_cpu_o,
  output logic [LW-1:0]             dlv_line_o
);
  logic [NUM_LINES-1:0]     acc_oh;
  logic [LW-1:0]            acc_idx;
  logic                     acc_any;
  logic [CW-1:0]            fix_cpu;
  route_mode_e              acc_mode;
  logic [CW-1:0]            bal_cpu;
  logic [CW-1:0]            tgt_cpu;
  logic [NUM_CPU-1:0]       tgt_oh;
  logic [NUM_CPU*CNT_W-1:0] cnt_flat;
  logic                     bal_upd;

  logic                     dlv_valid_q;
  logic [NUM_CPU-1:0]       dlv_cpu_q;
  logic [LW-1:0]            dlv_line_q;
  logic                     dlv_dyn_q;

  irq_dist_pick #(.N(NUM_LINES)) pick_i (
    .valid_i (req_valid_i),
    .grant_o (acc_oh),
    .idx_o   (acc_idx),
    .any_o   (acc_any)
  );

  irq_dist_table #(.NUM_LINES(NUM_LINES), .NUM_CPU(NUM_CPU)) table_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .wline_i (tbl_line_i),
    .wcpu_i  (tbl_cpu_i),
    .wdyn_i  (tbl_dyn_i),
    .rline_i (acc_idx),
    .rcpu_o  (fix_cpu),
    .rmode_o (acc_mode)
  );

  irq_dist_bal_sel #(.NUM_CPU(NUM_CPU), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) sel_i (
    .prio_i (cpu_prio_i),
    .cnt_i  (cnt_flat),
    .win_o  (bal_cpu)
  );

  assign bal_upd = acc_any && (acc_mode == MODE_BAL);

  irq_dist_fair_cnt #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (bal_upd),
    .win_i  (bal_cpu),
    .cnt_o  (cnt_flat)
  );

  assign tgt_cpu = (acc_mode == MODE_BAL) ? bal_cpu : fix_cpu;

  always_comb begin
    tgt_oh          = '0;
    tgt_oh[tgt_cpu] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_valid_q <= 1'b0;
      dlv_cpu_q   <= '0;
      dlv_line_q  <= '0;
      dlv_dyn_q   <= 1'b0;
    end else begin
      dlv_valid_q <= acc_any;
      if (acc_any) begin
        dlv_cpu_q  <= tgt_oh;
        dlv_line_q <= acc_idx;
        dlv_dyn_q  <= (acc_mode == MODE_BAL);
      end
    end
  end

  assign req_ready_o = acc_oh;
  assign dlv_valid_o = dlv_valid_q;
  assign dlv_cpu_o   = dlv_cpu_q;
  assign dlv_line_o  = dlv_line_q;
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk #(
  parameter int unsigned NUM_CPU   = 4,
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned PRIO_W    = 4,
  parameter int unsigned CNT_W     = 8,
  localparam int unsigned LW = $clog2(NUM_LINES)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_LINES-1:0]      req_valid_i,
  input logic [NUM_LINES-1:0]      req_ready_i,
  input logic [NUM_CPU*PRIO_W-1:0] cpu_prio_i,
  input logic                      dlv_valid_i,
  input logic [NUM_CPU-1:0]        dlv_cpu_i,
  input logic [LW-1:0]             dlv_line_i,
  input logic                      dlv_dyn_i,
  input logic [NUM_CPU*CNT_W-1:0]  cnt_i
);
  logic [NUM_CPU*PRIO_W-1:0] prio_d;
  logic [NUM_LINES-1:0]      ready_d;
  logic                      acc;
  logic                      low_ok;
  logic [CNT_W-1:0]          win_cnt;

  assign acc = |(req_valid_i & req_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_d  <= '0;
      ready_d <= '0;
    end else begin
      prio_d  <= cpu_prio_i;
      ready_d <= req_ready_i;
    end
  end

  always_comb begin
    low_ok  = 1'b1;
    win_cnt = '0;
    for (int w = 0; w < int'(NUM_CPU); w++) begin
      if (dlv_cpu_i[w]) begin
        win_cnt = cnt_i[w*CNT_W +: CNT_W];
        for (int c = 0; c < int'(NUM_CPU); c++)
          if (prio_d[c*PRIO_W +: PRIO_W] < prio_d[w*PRIO_W +: PRIO_W]) low_ok = 1'b0;
      end
    end
  end

  assert_ready_shape_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_i) && ((req_ready_i & ~req_valid_i) == '0));
  assert_ready_lowest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_valid_i) |-> ((req_ready_i != '0) &&
                       ((req_valid_i & (req_ready_i - NUM_LINES'(1))) == '0)));
  assert_dlv_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (dlv_valid_i && $countones(dlv_cpu_i) == 1));
  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !dlv_valid_i);
  assert_line_was_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_i |-> ready_d[dlv_line_i]);
  assert_bal_lowest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && dlv_dyn_i) |-> low_ok);
  assert_winner_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && dlv_dyn_i) |-> (win_cnt == '0));
  assert_fixed_keeps_cnt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && !dlv_dyn_i) |-> $stable(cnt_i));
  assert_idle_keeps_cnt_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dlv_valid_i |-> $stable(cnt_i));

  for (genvar g = 0; g < int'(NUM_CPU); g++) begin : g_sat
    assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cnt_i[g*CNT_W +: CNT_W]) == '1) |->
        ((cnt_i[g*CNT_W +: CNT_W] == '1) || (cnt_i[g*CNT_W +: CNT_W] == '0)));
  end
endmodule

bind irq_dist_top irq_dist_chk #(
  .NUM_CPU(NUM_CPU), .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_i (req_ready_o),
  .cpu_prio_i  (cpu_prio_i),
  .dlv_valid_i (dlv_valid_o),
  .dlv_cpu_i   (dlv_cpu_o),
  .dlv_line_i  (dlv_line_o),
  .dlv_dyn_i   (dlv_dyn_q),
  .cnt_i       (cnt_flat)
);

// File: tb/irq_dist_top_tb_top.sv
`timescale 1ns/1ps
module irq_dist_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req_valid;
  logic [15:0] req_ready;
  logic [15:0] cpu_prio;
  logic        tbl_we;
  logic [3:0]  tbl_line;
  logic [1:0]  tbl_cpu;
  logic        tbl_dyn;
  logic        dlv_valid;
  logic [3:0]  dlv_cpu;
  logic [3:0]  dlv_line;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  int m_cpu [16];
  bit m_dyn [16];
  int m_cnt [4];
  int m_prio[4];

  always #2.5 clk = ~clk;

  irq_dist_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .cpu_prio_i(cpu_prio),
    .tbl_we_i(tbl_we), .tbl_line_i(tbl_line), .tbl_cpu_i(tbl_cpu), .tbl_dyn_i(tbl_dyn),
    .dlv_valid_o(dlv_valid), .dlv_cpu_o(dlv_cpu), .dlv_line_o(dlv_line)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int model_pick(input int line);
    int best;
    if (!m_dyn[line]) return m_cpu[line];
    best = 0;
    for (int c = 1; c < 4; c++)
      if (m_prio[c] < m_prio[best] ||
          (m_prio[c] == m_prio[best] && m_cnt[c] > m_cnt[best])) best = c;
    for (int c = 0; c < 4; c++)
      if (c == best) m_cnt[c] = 0;
      else if (m_cnt[c] < 255) m_cnt[c]++;
    return best;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_valid = '0; cpu_prio = '0;
    tbl_we = 1'b0; tbl_line = '0; tbl_cpu = '0; tbl_dyn = 1'b0;
    for (int i = 0; i < 16; i++) begin m_cpu[i] = 0; m_dyn[i] = 0; end
    for (int c = 0; c < 4; c++) begin m_cnt[c] = 0; m_prio[c] = 0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_prio(input int p0, input int p1, input int p2, input int p3);
    @(negedge clk);
    m_prio[0] = p0; m_prio[1] = p1; m_prio[2] = p2; m_prio[3] = p3;
    cpu_prio = {4'(p3), 4'(p2), 4'(p1), 4'(p0)};
  endtask

  task automatic write_tbl(input int line, input int cpu, input bit dyn);
    @(negedge clk);
    tbl_we = 1'b1; tbl_line = 4'(line); tbl_cpu = 2'(cpu); tbl_dyn = dyn;
    m_cpu[line] = cpu; m_dyn[line] = dyn;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic run_reqs(input logic [15:0] mask, input string rq);
    logic [15:0] pend, low;
    int line, expc;
    pend = mask;
    while (pend != '0) begin
      @(negedge clk);
      req_valid = pend;
      #1;
      low = pend & (~pend + 16'd1);
      chk(req_ready == low, "R1", "ready", int'(req_ready), int'(low));
      line = 0;
      for (int i = 15; i >= 0; i--) if (pend[i]) line = i;
      expc = model_pick(line);
      @(posedge clk); #1;
      chk(dlv_valid == 1'b1, "R2", "dlv_valid", int'(dlv_valid), 1);
      chk(dlv_line == 4'(line), "R2", "dlv_line", int'(dlv_line), line);
      chk(dlv_cpu == 4'(1 << expc), rq, "dlv_cpu", int'(dlv_cpu), 1 << expc);
      pend &= ~low;
    end
    @(negedge clk);
    req_valid = '0;
    @(posedge clk); #1;
    chk(dlv_valid == 1'b0, "R2", "dlv_valid drop", int'(dlv_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(dlv_valid == 1'b0, "R10", "dlv_valid after reset", int'(dlv_valid), 0);
    chk(req_ready == '0, "R1", "ready idle", int'(req_ready), 0);
    run_reqs(16'h0020, "R10");
    run_reqs(16'h8000, "R10");
  endtask

  task automatic t_fixed();
    write_tbl(3, 2, 0);
    write_tbl(12, 3, 0);
    run_reqs(16'h0008, "R3");
    run_reqs(16'h1000, "R3");
    write_tbl(3, 1, 0);
    run_reqs(16'h0008, "R4");
  endtask

  task automatic t_multi();
    write_tbl(2, 1, 0);
    write_tbl(7, 3, 0);
    write_tbl(9, 0, 0);
    run_reqs(16'h0284, "R1");
  endtask

  task automatic t_bal_low();
    write_tbl(6, 3, 1);
    set_prio(5, 2, 9, 7);
    run_reqs(16'h0040, "R5");
    set_prio(3, 3, 1, 0);
    run_reqs(16'h0040, "R5");
    set_prio(8, 1, 8, 9);
    run_reqs(16'h0040, "R5");
  endtask

  task automatic t_tie_cnt();
    set_prio(4, 4, 4, 4);
    run_reqs(16'h0040, "R6");
    run_reqs(16'h0040, "R6");
    set_prio(2, 9, 2, 2);
    run_reqs(16'h0040, "R6");
  endtask

  task automatic t_tie_idx();
    do_reset();
    write_tbl(0, 0, 1);
    set_prio(6, 6, 6, 6);
    run_reqs(16'h0001, "R7");
    run_reqs(16'h0001, "R7");
    set_prio(6, 6, 3, 3);
    run_reqs(16'h0001, "R7");
  endtask

  task automatic t_fixed_keeps();
    write_tbl(10, 2, 0);
    run_reqs(16'h0400, "R3");
    run_reqs(16'h0400, "R3");
    repeat (3) @(negedge clk);
    set_prio(5, 5, 5, 5);
    run_reqs(16'h0001, "R9");
    run_reqs(16'h0001, "R9");
  endtask

  task automatic t_sat();
    do_reset();
    write_tbl(4, 0, 1);
    set_prio(0, 15, 15, 15);
    for (int k = 0; k < 256; k++) run_reqs(16'h0010, "R8");
    set_prio(7, 7, 7, 7);
    run_reqs(16'h0010, "R8");
    run_reqs(16'h0010, "R8");
    run_reqs(16'h0010, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fixed();
    t_multi();
    t_bal_low();
    t_tie_cnt();
    t_tie_idx();
    t_fixed_keeps();
    t_sat();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule